// File: doc/BRIEF.md
# Register and Immediate Integer Execute Unit

This block is the integer execute stage of a 32-bit load/store core, together with the register file that feeds it. Each instruction names a destination register, a first source register, and a second operand. The second operand is either another register or a 16-bit constant carried in the instruction. The unit reads both sources, extends the constant when the operation needs one, and computes the result. On the clock edge that accepts the instruction, it writes the result back to the destination register and loads the result into a one-deep output register.

Instructions arrive on a valid/ready stream, and results leave on another. The rules for back-pressure are as follows:
- An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or the consumer is taking its content in the same cycle.
- A result presented with `out_valid` high stays unchanged until `out_ready` is seen high.
- The write to the destination register happens at acceptance. The very next accepted instruction therefore already reads the new value.

Register 0 always reads as zero, and writes aimed at it are discarded. Operation codes are 4 bits wide. When bit 3 is set, the second operand is taken from the immediate field.

Top module: `rix_exec_unit`

## Requirements
- R1: After reset, `out_valid` is low and every register, including register 0, reads as zero.
- R2: `in_ready` equals `!out_valid || out_ready`. Acceptance makes `out_valid` high on the next cycle. While `out_valid` is high and `out_ready` is low, `out_result` and `out_dst` hold their values.
- R3: The register forms give `rs_a + rs_b` for code 0x0, `rs_a - rs_b` for 0x1, AND for 0x2, OR for 0x3 and XOR for 0x4. Sums and differences wrap modulo 2^32, with no overflow indication.
- R4: Set-less-than (code 0x5) gives 1 when `rs_a` is less than `rs_b` as a two's-complement signed value, and 0 otherwise, including when the two are equal.
- R5: Add-immediate (0x8) and set-less-than-immediate (0x9) sign-extend `in_imm` from 16 to 32 bits, so the constant spans -32768 to +32767.
- R6: AND-immediate (0xA) and OR-immediate (0xB) zero-extend `in_imm`.
- R7: Load-upper (0xC) gives `{in_imm, 16'h0000}`. A following OR-immediate on the same register fills bits 15..0, so 0x003D followed by 0x0900 yields 0x003D0900.
- R8: Register 0 reads as zero on both read ports. An instruction with destination 0 still presents its computed result on `out_result`, but register 0 remains zero.
- R9: An accepted result is written to a non-zero destination register on the acceptance edge and is read by the next accepted instruction, even when that instruction is accepted in the immediately following cycle.
- R10: Unassigned codes (0x6, 0x7, 0xD, 0xE, 0xF) produce a result of 0, which is presented and written like any other result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_op | input | 4 | Operation code |
| in_dst | input | 5 | Destination register index |
| in_src_a | input | 5 | First source register index |
| in_src_b | input | 5 | Second source register index, used by register forms |
| in_imm | input | 16 | Immediate constant, used by immediate forms |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_dst | output | 5 | Destination index of the presented result |
| out_result | output | 32 | Presented result |

## Verification
The bench exercises the following corner cases:
- Immediates with bit 15 set, through both the sign-extending and the zero-extending forms. A unit that mixes up the two extensions returns 0xFFFF8000 where 0x00008000 is due, or the reverse.
- Signed comparison between the most negative and most positive words, and between equal values. An unsigned or off-by-one compare returns the inverted bit.
- Additions that wrap past 0x7FFFFFFF.
- Writes aimed at register 0 followed by reads of it, which expose a register 0 that stores data.
- Back-to-back dependent instructions under random output stalls. A late write-back or a result that changes during a stall shows up here as a stale operand or a changed value.

// File: rtl/rix_pkg.sv
package rix_pkg;

  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_AND  = 4'h2,
    OP_OR   = 4'h3,
    OP_XOR  = 4'h4,
    OP_SLT  = 4'h5,
    OP_ADDI = 4'h8,
    OP_SLTI = 4'h9,
    OP_ANDI = 4'hA,
    OP_ORI  = 4'hB,
    OP_LUI  = 4'hC
  } op_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_SLT, FN_PASSB, FN_ZERO
  } fn_e;

  // how the second operand is formed
  typedef enum logic [1:0] {
    SRC_REG, SRC_SEXT, SRC_ZEXT, SRC_HIGH
  } src_e;

  typedef struct packed {
    fn_e  fn;
    src_e src;
  } ctl_t;

endpackage

// File: rtl/rix_decode.sv
module rix_decode
  import rix_pkg::*;
(
  input  logic [OPW-1:0] op,
  output ctl_t           ctl
);

  always_comb begin
    ctl = '{fn: FN_ZERO, src: SRC_REG};
    case (op)
      OP_ADD:  ctl = '{fn: FN_ADD,   src: SRC_REG};
      OP_SUB:  ctl = '{fn: FN_SUB,   src: SRC_REG};
      OP_AND:  ctl = '{fn: FN_AND,   src: SRC_REG};
      OP_OR:   ctl = '{fn: FN_OR,    src: SRC_REG};
      OP_XOR:  ctl = '{fn: FN_XOR,   src: SRC_REG};
      OP_SLT:  ctl = '{fn: FN_SLT,   src: SRC_REG};
      OP_ADDI: ctl = '{fn: FN_ADD,   src: SRC_SEXT};
      OP_SLTI: ctl = '{fn: FN_SLT,   src: SRC_SEXT};
      OP_ANDI: ctl = '{fn: FN_AND,   src: SRC_ZEXT};
      OP_ORI:  ctl = '{fn: FN_OR,    src: SRC_ZEXT};
      OP_LUI:  ctl = '{fn: FN_PASSB, src: SRC_HIGH};
      default: ctl = '{fn: FN_ZERO,  src: SRC_REG};
    endcase
  end

endmodule

// File: rtl/rix_operand.sv
module rix_operand
  import rix_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IMMW = 16
) (
  input  src_e            src,
  input  logic [XLEN-1:0] reg_val,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] opnd
);

  localparam int unsigned PADW = XLEN - IMMW;

  always_comb begin
    unique case (src)
      SRC_SEXT: opnd = {{PADW{imm[IMMW-1]}}, imm};
      SRC_ZEXT: opnd = {{PADW{1'b0}}, imm};
      SRC_HIGH: opnd = {imm, {PADW{1'b0}}};
      default:  opnd = reg_val;
    endcase
  end

endmodule

// File: rtl/rix_alu.sv
module rix_alu
  import rix_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  fn_e             fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  logic lt_signed;
  assign lt_signed = $signed(a) < $signed(b);

  always_comb begin
    unique case (fn)
      FN_ADD:   y = a + b;
      FN_SUB:   y = a - b;
      FN_AND:   y = a & b;
      FN_OR:    y = a | b;
      FN_XOR:   y = a ^ b;
      FN_SLT:   y = {{(XLEN-1){1'b0}}, lt_signed};
      FN_PASSB: y = b;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/rix_regfile.sv
module rix_regfile #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREGS = 32,
  parameter int unsigned NRD   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NREGS)-1:0] rd_addr [NRD],
  output logic [XLEN-1:0]          rd_data [NRD],
  input  logic                     wr_en,
  input  logic [$clog2(NREGS)-1:0] wr_addr,
  input  logic [XLEN-1:0]          wr_data
);

  localparam int unsigned AW = $clog2(NREGS);

  // storage exists only for registers 1..NREGS-1; register 0 is a constant
  logic [XLEN-1:0] mem [1:NREGS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i < NREGS; i++) mem[i] <= '0;
    end else if (wr_en && wr_addr != '0) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = (rd_addr[p] == AW'(0)) ? '0 : mem[rd_addr[p]];
  end

  // R9: a write to a real register lands one edge later
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0) |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/rix_exec_unit.sv
module rix_exec_unit
  import rix_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMMW  = 16,
  parameter int unsigned NREGS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [OPW-1:0]           in_op,
  input  logic [$clog2(NREGS)-1:0] in_dst,
  input  logic [$clog2(NREGS)-1:0] in_src_a,
  input  logic [$clog2(NREGS)-1:0] in_src_b,
  input  logic [IMMW-1:0]          in_imm,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [$clog2(NREGS)-1:0] out_dst,
  output logic [XLEN-1:0]          out_result
);

  localparam int unsigned AW = $clog2(NREGS);

  ctl_t            ctl;
  logic [AW-1:0]   rd_addr [2];
  logic [XLEN-1:0] rd_data [2];
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] alu_y;
  logic            accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  assign rd_addr[0] = in_src_a;
  assign rd_addr[1] = in_src_b;

  rix_decode u_dec (
    .op  (in_op),
    .ctl (ctl)
  );

  rix_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NRD(2)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (accept),
    .wr_addr (in_dst),
    .wr_data (alu_y)
  );

  rix_operand #(.XLEN(XLEN), .IMMW(IMMW)) u_opnd (
    .src     (ctl.src),
    .reg_val (rd_data[1]),
    .imm     (in_imm),
    .opnd    (opnd_b)
  );

  rix_alu #(.XLEN(XLEN)) u_alu (
    .fn (ctl.fn),
    .a  (rd_data[0]),
    .b  (opnd_b),
    .y  (alu_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_dst    <= '0;
      out_result <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_dst    <= in_dst;
      out_result <= alu_y;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R2: a stalled result holds still
  p_hold_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_dst)));

  // R2: acceptance yields a result on the next cycle
  p_accept_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R4: set-less-than results are a single bit
  p_slt_bool_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_op == OP_SLT || in_op == OP_SLTI)) |=> out_result[XLEN-1:1] == '0);

  // R7: load-upper clears the low half
  p_lui_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_LUI) |=> out_result[XLEN-IMMW-1:0] == '0);

  // R8: OR of register 0 with itself is zero
  p_zero_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == OP_OR && in_src_a == '0 && in_src_b == '0) |=> out_result == '0);

endmodule

// File: tb/rix_exec_unit_test.sv
module rix_exec_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [4:0]  in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_dst;
  logic [31:0] out_result;

  always #2 clk = ~clk;

  rix_exec_unit uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_dst(out_dst), .out_result(out_result)
  );

  typedef struct {
    logic [31:0] res;
    logic [4:0]  dst;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] mregs [32];
  int          checks = 0;
  int          fails = 0;
  bit          last_acc;
  bit          rand_ready = 0;
  string       cur_tag = "R3";
  bit          done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] imm);
    logic [31:0] sx, zx;
    sx = 32'(signed'(imm));
    zx = {16'h0, imm};
    case (op)
      4'h0: return a + b;
      4'h1: return a - b;
      4'h2: return a & b;
      4'h3: return a | b;
      4'h4: return a ^ b;
      4'h5: return (signed'(a) < signed'(b)) ? 32'd1 : 32'd0;
      4'h8: return a + sx;
      4'h9: return (signed'(a) < signed'(sx)) ? 32'd1 : 32'd0;
      4'hA: return a & zx;
      4'hB: return a | zx;
      4'hC: return {imm, 16'h0};
      default: return 32'h0;  // R10
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4: return "R3";
      4'h5: return "R4";
      4'h8, 4'h9: return "R5";
      4'hA, 4'hB: return "R6";
      4'hC: return "R7";
      default: return "R10";
    endcase
  endfunction

  // one clock: checks before the edge, then advance to the next falling edge
  task automatic cycle();
    bit fire, acc;
    exp_t e;
    out_ready = rand_ready ? ($urandom % 4 != 0) : 1'b1;
    #1;
    check(out_valid == (exp_q.size() != 0), "R2", "out_valid", 32'(out_valid), 32'(exp_q.size() != 0));
    check(in_ready == (!out_valid || out_ready), "R2", "in_ready", 32'(in_ready), 32'(!out_valid || out_ready));
    fire = out_valid && out_ready;
    acc  = in_valid && in_ready;
    if (fire && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      check(out_result == e.res, e.tag, "out_result", out_result, e.res);
      check(out_dst == e.dst, e.tag, "out_dst", 32'(out_dst), 32'(e.dst));
    end
    if (acc) begin
      e.res = model(in_op, mregs[in_src_a], mregs[in_src_b], in_imm);
      e.dst = in_dst;
      e.tag = cur_tag;
      exp_q.push_back(e);
      if (in_dst != 0) mregs[in_dst] = e.res;  // R8: register 0 is never written
    end
    last_acc = acc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [3:0] op, input int d, input int a, input int b,
                       input logic [15:0] imm, input string tag);
    in_op = op; in_dst = 5'(d); in_src_a = 5'(a); in_src_b = 5'(b); in_imm = imm;
    in_valid = 1'b1;
    cur_tag = tag;
    do cycle(); while (!last_acc);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) cycle();
    cycle();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mregs[i] = '0;
    repeat (3) @(negedge clk);
    // R1: idle output during and right after reset
    check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
    // R1: every register reads zero (OR into register 0)
    for (int i = 0; i < 32; i++) issue(4'h3, 0, i, 0, 16'h0, "R1");
    drain();

    // R7 constant building, R9 back-to-back dependency
    issue(4'hC, 1, 0, 0, 16'h003D, "R7");
    issue(4'hB, 1, 1, 0, 16'h0900, "R7");
    issue(4'h0, 13, 1, 1, 16'h0, "R9");
    // R5 sign extension
    issue(4'h8, 2, 0, 0, 16'hFFFF, "R5");
    issue(4'h8, 3, 0, 0, 16'h7FFF, "R5");
    issue(4'h8, 14, 0, 0, 16'h8000, "R5");
    // R6 zero extension
    issue(4'hA, 4, 2, 0, 16'hFFFF, "R6");
    issue(4'hB, 5, 0, 0, 16'h8000, "R6");
    // R3 wrap and logic
    issue(4'h0, 6, 2, 2, 16'h0, "R3");
    issue(4'hC, 7, 0, 0, 16'h7FFF, "R7");
    issue(4'hB, 7, 7, 0, 16'hFFFF, "R6");
    issue(4'h8, 8, 7, 0, 16'h0001, "R3");
    issue(4'h1, 9, 0, 1, 16'h0, "R3");
    issue(4'h2, 15, 1, 4, 16'h0, "R3");
    issue(4'h4, 16, 1, 2, 16'h0, "R3");
    issue(4'h3, 17, 5, 1, 16'h0, "R3");
    // R4 signed compare
    issue(4'h5, 10, 2, 0, 16'h0, "R4");
    issue(4'h5, 10, 0, 2, 16'h0, "R4");
    issue(4'h5, 10, 8, 7, 16'h0, "R4");
    issue(4'h5, 10, 7, 7, 16'h0, "R4");
    issue(4'h9, 11, 2, 0, 16'h0000, "R5");
    issue(4'h9, 11, 0, 0, 16'hFFFF, "R5");
    issue(4'h9, 11, 14, 0, 16'h8000, "R5");
    // R8 write to register 0 is shown but not stored
    issue(4'h8, 0, 0, 0, 16'h0005, "R8");
    issue(4'h3, 12, 0, 0, 16'h0, "R8");
    issue(4'h0, 12, 0, 1, 16'h0, "R8");
    // R10 unassigned codes
    issue(4'h6, 18, 1, 1, 16'h1234, "R10");
    issue(4'hD, 19, 1, 1, 16'h1234, "R10");
    issue(4'hF, 1, 1, 1, 16'h1234, "R10");
    drain();

    // R2 random traffic with stalls and gaps
    rand_ready = 1;
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op;
      op = 4'($urandom);
      if ($urandom % 3 == 0) cycle();
      issue(op, $urandom % 32, $urandom % 32, $urandom % 32, 16'($urandom), tag_of(op));
    end
    rand_ready = 0;
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule